// File: doc/BRIEF.md
# Circular trace capture buffer

This block is a trace sink that records a stream of 32-bit trace words into an on-chip ring of memory. Words arrive with a valid strobe and are stored at a write pointer that advances by one per word and wraps at the ring size. A sticky full flag records that the ring has wrapped. Once that flag is set, the oldest surviving word sits at the write pointer.

Software reaches the ring through a small word-addressed register bus. It can load either pointer, fill the ring through a write port that advances the write pointer, and drain it through a read port that advances the read pointer. It can arm a stop-after-trigger window, where a trigger pulse lets a programmed number of further words in and then halts capture. It can also request a manual flush. A flush pads a partly filled 4-word frame with zero words and then clears its own request bit. It can optionally halt capture as well. The level output `cap_done` reports that capture has halted.

Top module: `trace_ring_sink`

## Requirements
- R1: After reset, the control register (0x020), both pointers (0x014 read, 0x018 write) and the status register (0x00C) read 0. The formatter status register (0x300) reads 0x2. The depth register (0x004) reads DEPTH, with bit 31 clear. `cap_done` is 0.
- R2: Each bus write to 0x024 stores the data at the write pointer and advances the pointer by one. The pointer wraps from DEPTH-1 to 0.
- R3: Each bus read of 0x010 returns the word at the read pointer and advances the pointer, wrapping at DEPTH. Every read is answered with `bus_rvalid` high exactly one cycle after the request.
- R4: A write to 0x014 or 0x018 loads that pointer directly. A write to 0x018 also clears the full flag.
- R5: Status bit 0 (full) sets when any ring write advances the write pointer from DEPTH-1 to 0. It stays set until the write pointer is written.
- R6: Control bit 0 enables capture. A trace word with `trace_valid` high is stored only while capture is enabled, not halted and not flushing. Otherwise it is ignored and the write pointer holds.
- R7: With flush-control bit 13 set, a trigger pulse during active capture sets status bit 1. The word in the trigger cycle is stored, followed by exactly N more words, where N is the value in 0x01C. Capture then halts: status bit 2 and `cap_done` go to 1. A trigger while capture is disabled is ignored.
- R8: Writing the control register with bit 0 set clears the triggered and halted state.
- R9: Writing 0x304 with bit 6 set starts a flush. Bit 6 reads 1 while the flush runs. Zero words are written until the write pointer is a multiple of 4; an already aligned pointer does not move. Bit 6 then reads 0. Trace words arriving during the flush are not stored.
- R10: If flush-control bit 12 is set, completing a flush halts capture (status bit 2, `cap_done`). Formatter status bit 1 reads 1 while capture is halted or disabled. Formatter status bit 0 reads 1 while a flush is in progress.
- R11: Registers 0x01C, 0x020 and flush-control bits 0, 12 and 13 read back the values last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response, one cycle after bus_rd |
| trace_valid | input | 1 | Trace word strobe |
| trace_data | input | 32 | Trace word |
| trig_in | input | 1 | Trigger pulse |
| cap_done | output | 1 | Capture has halted |

## Verification
The ring is first filled through the bus port past its end. This shows a clean wrap and the full flag apart from an off-by-one pointer. Trace capture is then driven in three patterns, each telling a different stop condition apart from free running:
- with capture disabled, which checks that words and triggers are dropped;
- with a trigger and a counter of two, which checks the exact last stored word;
- with a flush, both from an unaligned pointer and from an aligned one.

For the unaligned flush, a trace word is sent while the flush is still in progress. The locations beyond the padding are then read back to prove that word was not written.

// File: rtl/trace_ring_pkg.sv
package trace_ring_pkg;
  // word addresses (byte address / 4)
  localparam logic [9:0] A_DEPTH = 10'h001;
  localparam logic [9:0] A_STAT  = 10'h003;
  localparam logic [9:0] A_RDATA = 10'h004;
  localparam logic [9:0] A_RPTR  = 10'h005;
  localparam logic [9:0] A_WPTR  = 10'h006;
  localparam logic [9:0] A_TRG   = 10'h007;
  localparam logic [9:0] A_CTL   = 10'h008;
  localparam logic [9:0] A_WDATA = 10'h009;
  localparam logic [9:0] A_FSTAT = 10'h0C0;
  localparam logic [9:0] A_FCTL  = 10'h0C1;

  localparam int FC_FMT_EN    = 0;
  localparam int FC_FLUSH     = 6;
  localparam int FC_STOP_FL   = 12;
  localparam int FC_STOP_TRIG = 13;

  typedef struct packed {
    logic full;
    logic triggered;
    logic stopped;
    logic flushing;
  } cap_stat_t;
endpackage

// File: rtl/trace_ring_ram.sv
module trace_ring_ram #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/trace_ring_capture.sv
module trace_ring_capture
  import trace_ring_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int FRAME = 4,
  parameter int CW    = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int FW = $clog2(FRAME)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  logic          stop_on_trig,
  input  logic          stop_on_flush,
  input  logic [CW-1:0] trg_count,
  input  logic          trace_valid,
  input  logic [31:0]   trace_data,
  input  logic          trig_in,
  input  logic          wp_load,
  input  logic [AW-1:0] wp_val,
  input  logic          bw_en,
  input  logic [31:0]   bw_data,
  input  logic          flush_go,
  input  logic          rearm,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [31:0]   ram_wdata,
  output logic [AW-1:0] wr_ptr,
  output cap_stat_t     stat
);
  logic [AW-1:0] wp_q;
  logic [CW-1:0] remain_q;
  logic full_q, trig_q, stop_q, flush_q;

  logic aligned, pad, flush_done, active, take;

  always_comb begin
    aligned    = (wp_q[FW-1:0] == '0);
    pad        = flush_q && !aligned && !bw_en;
    flush_done = flush_q && aligned && !bw_en;
    active     = cap_en && !stop_q && !flush_q;
    take       = trace_valid && active && !bw_en;
    ram_we     = bw_en || pad || take;
    ram_waddr  = wp_q;
    ram_wdata  = bw_en ? bw_data : (pad ? 32'h0 : trace_data);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q   <= '0;
      full_q <= 1'b0;
    end else if (wp_load) begin
      wp_q   <= wp_val;
      full_q <= 1'b0;
    end else if (ram_we) begin
      wp_q <= wp_q + 1'b1;
      if (wp_q == AW'(DEPTH - 1)) full_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flush_q <= 1'b0;
    else if (flush_go) flush_q <= 1'b1;
    else if (flush_done) flush_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || rearm) begin
      trig_q   <= 1'b0;
      stop_q   <= 1'b0;
      remain_q <= '0;
    end else begin
      if (flush_done && stop_on_flush) stop_q <= 1'b1;
      if (trig_in && active && !trig_q) begin
        trig_q   <= 1'b1;
        remain_q <= trg_count;
        if (stop_on_trig && trg_count == '0) stop_q <= 1'b1;
      end else if (trig_q && stop_on_trig && take) begin
        remain_q <= remain_q - 1'b1;
        if (remain_q <= CW'(1)) stop_q <= 1'b1;
      end
    end
  end

  assign wr_ptr         = wp_q;
  assign stat.full      = full_q;
  assign stat.triggered = trig_q;
  assign stat.stopped   = stop_q;
  assign stat.flushing  = flush_q;

  // R5: full flag only drops on a pointer load
  p_full_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    full_q && !wp_load |=> full_q);

  // R9: a flush always ends on a frame boundary
  p_flush_aligned_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(flush_q) |-> (wp_q[FW-1:0] == '0) || $past(wp_load) || $past(bw_en));

  // R7: a halted sink does not move the write pointer by itself
  p_stop_hold_r7: assert property (@(posedge clk) disable iff (rst)
    stop_q && !wp_load && !bw_en && !flush_q |=> $stable(wp_q));
endmodule

// File: rtl/trace_ring_regs.sv
module trace_ring_regs
  import trace_ring_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CW    = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [11:0]   bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          bus_rvalid,
  input  logic [31:0]   ram_q,
  output logic          ram_re,
  output logic [AW-1:0] ram_raddr,
  input  logic [AW-1:0] wr_ptr,
  input  cap_stat_t     stat,
  output logic          cap_en,
  output logic          stop_on_trig,
  output logic          stop_on_flush,
  output logic [CW-1:0] trg_count,
  output logic          wp_load,
  output logic [AW-1:0] wp_val,
  output logic          bw_en,
  output logic [31:0]   bw_data,
  output logic          flush_go,
  output logic          rearm
);
  logic [9:0]    waddr;
  logic          ctl_q, fmt_q, sof_q, sot_q;
  logic [CW-1:0] trg_q;
  logic [AW-1:0] rp_q;
  logic [31:0]   rdata_q, rd_val;
  logic          rvalid_q, rsp_ram_q;
  logic          unused_bits;

  assign waddr       = bus_addr[11:2];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata};

  assign ram_re    = bus_rd && waddr == A_RDATA;
  assign ram_raddr = rp_q;
  assign wp_load   = bus_wr && waddr == A_WPTR;
  assign wp_val    = bus_wdata[AW-1:0];
  assign bw_en     = bus_wr && waddr == A_WDATA;
  assign bw_data   = bus_wdata;
  assign flush_go  = bus_wr && waddr == A_FCTL && bus_wdata[FC_FLUSH];
  assign rearm     = bus_wr && waddr == A_CTL && bus_wdata[0];

  assign cap_en        = ctl_q;
  assign stop_on_trig  = sot_q;
  assign stop_on_flush = sof_q;
  assign trg_count     = trg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= 1'b0; fmt_q <= 1'b0; sof_q <= 1'b0; sot_q <= 1'b0;
      trg_q <= '0;
    end else if (bus_wr) begin
      if (waddr == A_CTL) ctl_q <= bus_wdata[0];
      if (waddr == A_TRG) trg_q <= bus_wdata[CW-1:0];
      if (waddr == A_FCTL) begin
        fmt_q <= bus_wdata[FC_FMT_EN];
        sof_q <= bus_wdata[FC_STOP_FL];
        sot_q <= bus_wdata[FC_STOP_TRIG];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rp_q <= '0;
    else if (bus_wr && waddr == A_RPTR) rp_q <= bus_wdata[AW-1:0];
    else if (ram_re) rp_q <= rp_q + 1'b1;
  end

  always_comb begin
    rd_val = '0;
    case (waddr)
      A_DEPTH: rd_val = 32'(DEPTH) & 32'h7FFF_FFFF;
      A_STAT:  rd_val = {29'd0, stat.stopped, stat.triggered, stat.full};
      A_RPTR:  rd_val = 32'(rp_q);
      A_WPTR:  rd_val = 32'(wr_ptr);
      A_TRG:   rd_val = 32'(trg_q);
      A_CTL:   rd_val = {31'd0, ctl_q};
      A_FSTAT: rd_val = {30'd0, stat.stopped || !ctl_q, stat.flushing};
      A_FCTL: begin
        rd_val[FC_FMT_EN]    = fmt_q;
        rd_val[FC_FLUSH]     = stat.flushing;
        rd_val[FC_STOP_FL]   = sof_q;
        rd_val[FC_STOP_TRIG] = sot_q;
      end
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q   <= '0;
      rvalid_q  <= 1'b0;
      rsp_ram_q <= 1'b0;
    end else begin
      rvalid_q  <= bus_rd;
      rsp_ram_q <= ram_re;
      if (bus_rd) rdata_q <= rd_val;
    end
  end

  assign bus_rdata  = rsp_ram_q ? ram_q : rdata_q;
  assign bus_rvalid = rvalid_q;

  // R3: every read request is answered on the next cycle
  p_read_response_r3: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  // R3: read pointer wraps at the ring end
  p_read_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    ram_re && !bus_wr && rp_q == AW'(DEPTH - 1) |=> rp_q == '0);
endmodule

// File: rtl/trace_ring_sink.sv
module trace_ring_sink
  import trace_ring_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int FRAME = 4,
  parameter int CW    = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [11:0] bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid,
  input  logic        trace_valid,
  input  logic [31:0] trace_data,
  input  logic        trig_in,
  output logic        cap_done
);
  logic          ram_we, ram_re;
  logic [AW-1:0] ram_waddr, ram_raddr, wr_ptr, wp_val;
  logic [31:0]   ram_wdata, ram_q, bw_data;
  logic          cap_en, stop_on_trig, stop_on_flush;
  logic [CW-1:0] trg_count;
  logic          wp_load, bw_en, flush_go, rearm;
  cap_stat_t     stat;

  trace_ring_regs #(.DEPTH(DEPTH), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .ram_q(ram_q), .ram_re(ram_re), .ram_raddr(ram_raddr), .wr_ptr(wr_ptr),
    .stat(stat), .cap_en(cap_en), .stop_on_trig(stop_on_trig),
    .stop_on_flush(stop_on_flush), .trg_count(trg_count), .wp_load(wp_load),
    .wp_val(wp_val), .bw_en(bw_en), .bw_data(bw_data), .flush_go(flush_go),
    .rearm(rearm)
  );

  trace_ring_capture #(.DEPTH(DEPTH), .FRAME(FRAME), .CW(CW)) u_capture (
    .clk(clk), .rst(rst), .cap_en(cap_en), .stop_on_trig(stop_on_trig),
    .stop_on_flush(stop_on_flush), .trg_count(trg_count),
    .trace_valid(trace_valid), .trace_data(trace_data), .trig_in(trig_in),
    .wp_load(wp_load), .wp_val(wp_val), .bw_en(bw_en), .bw_data(bw_data),
    .flush_go(flush_go), .rearm(rearm), .ram_we(ram_we), .ram_waddr(ram_waddr),
    .ram_wdata(ram_wdata), .wr_ptr(wr_ptr), .stat(stat)
  );

  trace_ring_ram #(.DEPTH(DEPTH), .WIDTH(32)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(ram_re), .raddr(ram_raddr), .rdata(ram_q)
  );

  assign cap_done = stat.stopped;
endmodule

// File: tb/tb_trace_ring_sink.sv
module tb_trace_ring_sink;
  localparam int DEPTH = 16;
  localparam logic [11:0] DEP = 12'h004, STAT = 12'h00C, RDAT = 12'h010,
    RPTR = 12'h014, WPTR = 12'h018, TRG = 12'h01C, CTL = 12'h020,
    WDAT = 12'h024, FSTA = 12'h300, FCTL = 12'h304;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0, trace_valid = 1'b0, trig_in = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, trace_data = '0, bus_rdata;
  logic bus_rvalid, cap_done;

  trace_ring_sink #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .trace_valid(trace_valid), .trace_data(trace_data), .trig_in(trig_in),
    .cap_done(cap_done)
  );

  int vectors = 0, miscompares = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // all stimulus tasks start and end on a falling edge
  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic trace(logic [31:0] d, logic trg);
    trace_data = d; trace_valid = 1'b1; trig_in = trg;
    @(negedge clk);
    trace_valid = 1'b0; trig_in = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare each read response with the scoreboard head
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) check("unexpected read response", bus_rdata, 32'hx);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  bit done = 1'b0;
  initial begin
    #(4 * 100000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state
    rd(DEP, DEPTH, "R1 depth");
    rd(STAT, 0, "R1 status");
    rd(FSTA, 32'h2, "R1 formatter status");
    rd(CTL, 0, "R1 control");
    rd(RPTR, 0, "R1 read pointer");
    rd(WPTR, 0, "R1 write pointer");
    check("R1 cap_done", {31'd0, cap_done}, 0);
    // R11 readback
    wr(TRG, 5);
    rd(TRG, 5, "R11 trigger counter");
    wr(FCTL, 32'h3001);
    rd(FCTL, 32'h3001, "R11 flush control");
    wr(FCTL, 0);
    // R2 / R5 fill through the bus port past the end
    for (int i = 0; i < DEPTH; i++) wr(WDAT, 32'h100 + i);
    rd(WPTR, 0, "R2 write pointer wrap");
    rd(STAT, 32'h1, "R5 full flag");
    // R3 read port with wrap, R4 pointer load
    wr(RPTR, 14);
    rd(RDAT, 32'h10E, "R3 read word 14");
    rd(RDAT, 32'h10F, "R3 read word 15");
    rd(RDAT, 32'h100, "R3 read wrap");
    rd(RPTR, 1, "R3 read pointer advance");
    wr(WPTR, 3);
    rd(STAT, 0, "R4 full cleared");
    rd(WPTR, 3, "R4 write pointer load");
    // R6 capture enable
    wr(WPTR, 0);
    for (int i = 0; i < 3; i++) trace(32'hDEAD0000 + i, 1'b0);
    rd(WPTR, 0, "R6 disabled ignored");
    wr(CTL, 1);
    for (int i = 0; i < 6; i++) trace(32'hA0 + i, 1'b0);
    rd(WPTR, 6, "R6 captured count");
    wr(RPTR, 0);
    for (int i = 0; i < 6; i++) rd(RDAT, 32'hA0 + i, "R6 captured word");
    // R7 trigger stop
    wr(CTL, 0);
    wr(WPTR, 0);
    wr(TRG, 2);
    wr(FCTL, 32'h2000);
    trace(32'hEE, 1'b1);
    rd(STAT, 0, "R7 trigger while disabled");
    rd(WPTR, 0, "R7 nothing stored while disabled");
    wr(CTL, 1);
    for (int i = 0; i < 7; i++) trace(32'hB0 + i, i == 2);
    rd(WPTR, 5, "R7 words after trigger");
    rd(STAT, 32'h6, "R7 triggered and halted");
    rd(FSTA, 32'h2, "R7 formatter stopped");
    check("R7 cap_done", {31'd0, cap_done}, 1);
    wr(RPTR, 0);
    for (int i = 0; i < 5; i++) rd(RDAT, 32'hB0 + i, "R7 stored word");
    // R8 rearm
    wr(CTL, 1);
    rd(STAT, 0, "R8 rearm clears state");
    check("R8 cap_done", {31'd0, cap_done}, 0);
    trace(32'hC0, 1'b0);
    rd(WPTR, 6, "R8 capture resumes");
    // R9 flush from unaligned pointer, trace word during flush dropped
    wr(FCTL, 0);
    wr(FCTL, 32'h40);
    rd(FCTL, 32'h40, "R9 flush bit while busy");
    trace(32'hD0, 1'b0);
    idle(3);
    rd(FCTL, 0, "R9 flush bit self clears");
    rd(WPTR, 8, "R9 padded to frame");
    wr(RPTR, 6);
    rd(RDAT, 0, "R9 pad word 6");
    rd(RDAT, 0, "R9 pad word 7");
    rd(RDAT, 32'h108, "R9 trace during flush not stored");
    wr(FCTL, 32'h40);
    idle(3);
    rd(WPTR, 8, "R9 aligned flush no pad");
    // R10 stop on flush
    wr(FCTL, 32'h1040);
    idle(3);
    rd(STAT, 32'h4, "R10 halted after flush");
    rd(FSTA, 32'h2, "R10 formatter stopped");
    check("R10 cap_done", {31'd0, cap_done}, 1);
    trace(32'hE0, 1'b0);
    rd(WPTR, 8, "R10 no capture after stop");
    rd(FCTL, 32'h1000, "R10 flush control");
    wr(CTL, 1);
    rd(FSTA, 0, "R8 formatter running after rearm");
    wr(CTL, 0);
    rd(FSTA, 32'h2, "R10 stopped when disabled");
    idle(3);
    if (exp_q.size() != 0) check("missing read responses", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule